// File: doc/BRIEF.md
# Packed Lane Integer ALU

This block is a 32-bit integer arithmetic unit that reads each operand either as one full word, as two independent 16-bit half-words, or as four independent 8-bit bytes. A 2-bit lane-size input selects the split. Every operation is carried out separately inside each lane. No carry, borrow, product bit or shifted-in sign bit ever crosses from one lane into its neighbour.

Eight operations are available: wrap-around add and subtract, the low half of an unsigned product, arithmetic right shift, bitwise AND, and three compare-and-set operations. A compare writes a lane of all ones where its condition holds and a lane of all zeros where it fails. That result can be ANDed straight onto data to clear the lanes that failed.

With the default parameter, the result passes through one output register and appears one clock after the operands. A parameter can remove the register and make the path purely combinational.

Top module: `psimd_alu`

## Requirements
- R1: Lane-size codes are 2'b00 = one 32-bit lane, 2'b01 = two 16-bit lanes (lane 0 in bits 15:0), and 2'b10 = four 8-bit lanes (lane 0 in bits 7:0). The spare code 2'b11 behaves exactly like 2'b00.
- R2: Add gives, in each lane, the lane sum modulo 2 to the lane width, and a carry out of one lane never reaches the next.
- R3: Subtract gives, in each lane, a minus b modulo 2 to the lane width, and a borrow never crosses a lane boundary.
- R4: Multiply gives, in each lane, the low lane-width bits of the unsigned product of the two lane values.
- R5: Arithmetic shift moves each lane of a right and fills with that lane's sign bit. The shift count is the low log2(lane width) bits of the matching lane of b, which makes it the count modulo the lane width.
- R6: AND gives the bitwise AND of a and b, and the result is the same under every lane size.
- R7: The compares (equal, signed less-than, unsigned less-than) set every bit of a lane to 1 when the condition holds for that lane, and every bit to 0 when it does not.
- R8: Opcode codes are 0 add, 1 subtract, 2 multiply, 3 arithmetic shift right, 4 AND, 5 set-equal, 6 set-less-than signed, 7 set-less-than unsigned.
- R9: With REG_OUT = 1 the result for the operands present at a rising clock edge appears after that edge and holds until the next one. A low rst_n at a rising edge clears the result to zero.
- R10: A compare result ANDed with data leaves the data unchanged in the lanes that passed and zero in the lanes that failed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code |
| mode_i | input | 2 | Lane-size code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, also the per-lane shift count |
| res_o | output | 32 | Result |

## Verification
The temporal properties assume the default registered build and assume that the operands, opcode and lane-size code stay steady from one rising edge to the next. Each property compares the result against the inputs sampled one edge earlier, and only when that earlier edge was outside reset. The bench changes inputs only on falling edges, and only after reset has been released. It sweeps every opcode under all four lane-size codes. The operands used are zero, all ones, the signed minimum of each lane size, its maximum, and random words. A compare-then-mask sequence and a latency probe are added to this.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_ASR  = 3'd3,
        OP_AND  = 3'd4,
        OP_SEQ  = 3'd5,
        OP_SLT  = 3'd6,
        OP_SLTU = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        PK_WORD = 2'b00,
        PK_HALF = 2'b01,
        PK_BYTE = 2'b10,
        PK_RSVD = 2'b11
    } pack_mode_e;

endpackage

// File: rtl/psimd_lane.sv
module psimd_lane
    import psimd_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  alu_op_e             op_i,
    input  logic [LANE_W-1:0]   a_i,
    input  logic [LANE_W-1:0]   b_i,
    output logic [LANE_W-1:0]   r_o
);
    localparam int SH_W = $clog2(LANE_W);

    logic [SH_W-1:0] shamt;
    logic            eq_hit;
    logic            lts_hit;
    logic            ltu_hit;

    // Shift count is modulo the lane width (R5).
    assign shamt   = b_i[SH_W-1:0];
    assign eq_hit  = (a_i == b_i);
    assign lts_hit = ($signed(a_i) < $signed(b_i));
    assign ltu_hit = (a_i < b_i);

    always_comb begin
        r_o = '0;
        case (op_i)
            OP_ADD:  r_o = a_i + b_i;
            OP_SUB:  r_o = a_i - b_i;
            OP_MUL:  r_o = a_i * b_i;
            OP_ASR:  r_o = $signed(a_i) >>> shamt;
            OP_AND:  r_o = a_i & b_i;
            OP_SEQ:  r_o = {LANE_W{eq_hit}};
            OP_SLT:  r_o = {LANE_W{lts_hit}};
            OP_SLTU: r_o = {LANE_W{ltu_hit}};
            default: r_o = '0;
        endcase
    end
endmodule

// File: rtl/psimd_lane_row.sv
module psimd_lane_row
    import psimd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  alu_op_e             op_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    output logic [DATA_W-1:0]   r_o
);
    localparam int N_LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        psimd_lane #(.LANE_W(LANE_W)) lane_i (
            .op_i (op_i),
            .a_i  (a_i[g*LANE_W +: LANE_W]),
            .b_i  (b_i[g*LANE_W +: LANE_W]),
            .r_o  (r_o[g*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/psimd_alu.sv
module psimd_alu
    import psimd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int BYTE_W = DATA_W / 4;

    typedef struct packed {
        logic [DATA_W-1:0] res;
    } alu_state_t;

    alu_op_e           op;
    pack_mode_e        mode;
    logic [DATA_W-1:0] word_r;
    logic [DATA_W-1:0] half_r;
    logic [DATA_W-1:0] byte_r;
    alu_state_t        st_d;

    assign op   = alu_op_e'(op_i);
    assign mode = pack_mode_e'(mode_i);

    psimd_lane_row #(.DATA_W(DATA_W), .LANE_W(DATA_W)) row_word_i (
        .op_i(op), .a_i(a_i), .b_i(b_i), .r_o(word_r)
    );
    psimd_lane_row #(.DATA_W(DATA_W), .LANE_W(HALF_W)) row_half_i (
        .op_i(op), .a_i(a_i), .b_i(b_i), .r_o(half_r)
    );
    psimd_lane_row #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) row_byte_i (
        .op_i(op), .a_i(a_i), .b_i(b_i), .r_o(byte_r)
    );

    // Lane-size select; the spare code falls back to whole word (R1).
    always_comb begin
        st_d = '0;
        case (mode)
            PK_HALF: st_d.res = half_r;
            PK_BYTE: st_d.res = byte_r;
            default: st_d.res = word_r;
        endcase
    end

    if (REG_OUT) begin : g_reg
        alu_state_t st_q;
        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end
        assign res_o = st_q.res;
    end else begin : g_comb
        assign res_o = st_d.res;
    end
endmodule

// File: rtl/psimd_alu_chk.sv
module psimd_alu_chk
    import psimd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic [1:0]        mode_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [DATA_W-1:0] res_o
);
    localparam int BW = DATA_W / 4;

    if (REG_OUT) begin : g_props
        a_r9_reset_clear: assert property (@(posedge clk)
            !rst_n |=> res_o == '0);

        a_r6_and_mode_free: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_i) == OP_AND) |-> res_o == $past(a_i & b_i));

        a_r2_byte_add_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_i) == OP_ADD && $past(mode_i) == PK_BYTE)
            |-> res_o[2*BW-1:BW] == BW'($past(a_i[2*BW-1:BW]) + $past(b_i[2*BW-1:BW])));

        a_r1_spare_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_i) == OP_ADD && $past(mode_i) == PK_RSVD)
            |-> res_o == DATA_W'($past(a_i) + $past(b_i)));

        a_r7_byte_mask_full: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_i) >= OP_SEQ && $past(mode_i) == PK_BYTE)
            |-> ((res_o[BW-1:0]      == '0 || res_o[BW-1:0]      == '1) &&
                 (res_o[2*BW-1:BW]   == '0 || res_o[2*BW-1:BW]   == '1) &&
                 (res_o[3*BW-1:2*BW] == '0 || res_o[3*BW-1:2*BW] == '1) &&
                 (res_o[4*BW-1:3*BW] == '0 || res_o[4*BW-1:3*BW] == '1)));
    end
endmodule

bind psimd_alu psimd_alu_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) chk_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .mode_i(mode_i),
    .a_i(a_i), .b_i(b_i), .res_o(res_o)
);

// File: tb/psimd_alu_tb.sv
`timescale 1ns/1ps
module psimd_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  mode = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [31:0] res;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    psimd_alu dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op), .mode_i(mode),
        .a_i(a), .b_i(b), .res_o(res)
    );

    // Independent per-lane reference model built from the requirements.
    function automatic logic [31:0] ref_alu(input logic [2:0] o, input logic [1:0] m,
                                            input logic [31:0] x, input logic [31:0] y);
        int lw;
        longint msk, la, lb, sa, sb, r;
        logic [31:0] acc;
        lw  = (m == 2'b01) ? 16 : (m == 2'b10) ? 8 : 32;
        msk = (longint'(1) << lw) - 1;
        acc = '0;
        for (int i = 0; i < 32 / lw; i++) begin
            la = (longint'(x) >> (i * lw)) & msk;
            lb = (longint'(y) >> (i * lw)) & msk;
            sa = (la >= (longint'(1) << (lw - 1))) ? la - (longint'(1) << lw) : la;
            sb = (lb >= (longint'(1) << (lw - 1))) ? lb - (longint'(1) << lw) : lb;
            case (o)
                3'd0: r = (la + lb) & msk;
                3'd1: r = (la - lb) & msk;
                3'd2: r = (la * lb) & msk;
                3'd3: r = (sa >>> (lb % lw)) & msk;
                3'd4: r = la & lb;
                3'd5: r = (la == lb) ? msk : 0;
                3'd6: r = (sa < sb) ? msk : 0;
                default: r = (la < lb) ? msk : 0;
            endcase
            acc = acc | 32'(r << (i * lw));
        end
        return acc;
    endfunction

    function automatic string op_tag(input logic [2:0] o, input logic [1:0] m);
        if (m == 2'b11) return "R1";
        case (o)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
        end
    endtask

    // Driver: new inputs on a falling edge, expectation into the scoreboard.
    task automatic drive(input logic [2:0] o, input logic [1:0] m,
                         input logic [31:0] x, input logic [31:0] y, input string req);
        @(negedge clk);
        op = o; mode = m; a = x; b = y;
        exp_q.push_back(ref_alu(o, m, x, y));
        tag_q.push_back(req);
    endtask

    // Monitor: one result per cycle, sampled 2 ns after the capturing edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, res, e);
            end
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        finish_run();
    end

    logic [31:0] pats [8] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8080_8080, 32'h7F7F_7F7F,
                              32'h8000_8000, 32'h8000_0000, 32'h0101_0101, 32'h00FF_FF01};

    initial begin
        logic [31:0] m;
        repeat (3) @(posedge clk);
        #2;
        check("R9 reset", res, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: one operand pair under every opcode in whole-word mode.
        for (int o = 0; o < 8; o++)
            drive(3'(o), 2'b00, 32'h1234_F0F0, 32'h0000_0004, "R8");

        // Boundary sweep: all opcodes, all lane-size codes, boundary pairs.
        for (int o = 0; o < 8; o++)
            for (int md = 0; md < 4; md++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j += 3)
                        drive(3'(o), 2'(md), pats[i], pats[j], op_tag(3'(o), 2'(md)));

        // Random sweep.
        for (int k = 0; k < 800; k++) begin
            logic [2:0] ro;
            logic [1:0] rm;
            ro = 3'($urandom_range(0, 7));
            rm = 2'($urandom_range(0, 3));
            drive(ro, rm, $urandom, $urandom, op_tag(ro, rm));
        end

        // R10: byte unsigned compare, then mask data with the result.
        drive(3'd7, 2'b10, 32'h1080_05FF, 32'h2090_0600, "R7");
        @(posedge clk); #3;
        m = res;
        check("R10 mask", m, 32'hFFFF_FF00);
        drive(3'd4, 2'b10, 32'hDEAD_BEEF, m, "R10");
        @(posedge clk); #3;
        check("R10 masked data", res, 32'hDEAD_BE00);

        // R9: result holds until the next edge, then updates.
        drive(3'd0, 2'b00, 32'd1, 32'd2, "R9");
        #2;
        check("R9 hold", res, 32'hDEAD_BE00);
        @(posedge clk); #3;
        check("R9 latency", res, 32'd3);

        repeat (3) @(posedge clk);
        #5;
        check("R9 queue drained", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule